// File: doc/BRIEF.md
# Segmented Hashed Page-Table Address Generator

This block is the front end of a 32-bit segmented memory-management unit. It holds sixteen segment descriptors and, for each lookup request, picks one descriptor with the top nibble of the effective address. From that descriptor it derives the protection key, the no-execute and direct-store attributes and a 24-bit segment identifier. From the identifier, the page index and a table-origin register it then computes the two candidate page-table group addresses, primary and secondary, and the tag that the page-table walker later compares against each entry.

Instruction fetches that hit a no-execute segment are rejected at once. Accesses that hit a direct-store segment never reach the page table: they are resolved here by access type and by the protection key. All results are registered and appear one cycle after the request, with a one-cycle valid strobe and a signed 3-bit status. The walker that fetches and matches page-table entries sits downstream and consumes the two group addresses and the tag.

Top module: `hpt_addr_gen`

## Requirements
- R1: The descriptor used for a lookup is the one indexed by effective-address bits 31:28. A descriptor write (`sr_wr_en`, `sr_wr_idx`, `sr_wr_data`) is seen by lookups issued in later cycles. A lookup issued in the same cycle as the write still sees the old content. All descriptors reset to zero.
- R2: `out_key` is descriptor bit 29 when `in_user` is 1 and descriptor bit 30 when `in_user` is 0.
- R3: Descriptor bit 31 marks a direct-store segment, bit 28 marks no-execute and bits 23:0 are the segment identifier (vsid).
- R4: For a page-translated access, with pidx = effective-address bits 27:12, hash = ((vsid ^ pidx) << 6) & 0x01FFFFC0 and mask = ((base & 0x1FF) << 16) | 0xFFC0, the primary address is (base & 0xFFFF0000) | (hash & mask).
- R5: The secondary address uses (~hash) & 0x01FFFFC0 in place of hash and is otherwise formed as in R4.
- R6: For a page-translated access the tag is (vsid << 7) | (pidx >> 10).
- R7: A non-direct-store segment with no-execute set, hit by an instruction fetch, gives status -3 (3'b101), zero addresses and tag, and a real address of all ones. A data access to the same segment is translated normally.
- R8: Access types are encoded INT=0, CODE=1, FLOAT=2, RES=3, CACHE=4 and EXT=5. In a direct-store segment, CODE, FLOAT, RES, EXT and the unused codes 6 and 7 give status -4 (3'b100). CACHE gives status 0 with real address = effective address, whatever the key.
- R9: An INT access to a direct-store segment is refused with status -2 (3'b110) when (read and key=1) or (write and key=0). Otherwise it gives status 2 (3'b010) with real address = effective address. The no-execute bit plays no part in direct-store segments.
- R10: The outputs change only in the cycle after `in_valid` is high. `out_valid` is high exactly in the cycle after each accepted request. All other outputs hold between requests.
- R11: A page-translated access gives status 1 (3'b001) and a real address of all ones. Any outcome other than R4 to R6 drives zero addresses and tag. Reset gives `out_valid`=0, status 0, key 0, zero addresses and tag, and a real address of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Descriptor write enable |
| sr_wr_idx | input | 4 | Descriptor write index |
| sr_wr_data | input | 32 | Descriptor write value |
| tbl_base | input | 32 | Page-table origin and size register |
| in_valid | input | 1 | Lookup request strobe |
| in_ea | input | 32 | Effective address |
| in_acc | input | 3 | Access type code |
| in_write | input | 1 | 1 = write, 0 = read |
| in_user | input | 1 | 1 = user mode, 0 = supervisor |
| out_valid | output | 1 | Result strobe |
| out_status | output | 3 | Signed outcome code |
| out_key | output | 1 | Protection key |
| out_pri_addr | output | 32 | Primary group address |
| out_sec_addr | output | 32 | Secondary group address |
| out_tag | output | 32 | Compare tag |
| out_real | output | 32 | Real address, or all ones |

## Verification
The bench runs table bases whose size field overlaps the origin bits, so a design that replaced the OR of origin and hash with a plain concatenation would produce a wrong primary address. The key sense is exercised in all four combinations of read/write and key on direct-store integer accesses, which catches any swap of the deny rule. A cache-management access is run against a key that would refuse it, and a code fetch hits a segment that has both direct-store and no-execute set, so a design that tested no-execute first would return -3 instead of -4. A descriptor write issued in the same cycle as a lookup catches a design that forwards the new value, and idle cycles after a result catch outputs that drift or strobe twice.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [2:0] {
      ACC_INT   = 3'd0,
      ACC_CODE  = 3'd1,
      ACC_FLOAT = 3'd2,
      ACC_RES   = 3'd3,
      ACC_CACHE = 3'd4,
      ACC_EXT   = 3'd5
   } acc_e;

   localparam logic [2:0] ST_CACHE_NOP = 3'b000;
   localparam logic [2:0] ST_PAGE      = 3'b001;
   localparam logic [2:0] ST_DS_OK     = 3'b010;
   localparam logic [2:0] ST_NOEXEC    = 3'b101;
   localparam logic [2:0] ST_DS_DENY   = 3'b110;
   localparam logic [2:0] ST_DS_BAD    = 3'b100;

endpackage

// File: rtl/hpt_seg_file.sv
module hpt_seg_file #(
   parameter int NUM_SEG = 16,
   parameter int SEG_W   = 32,
   localparam int IDX_W  = $clog2(NUM_SEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SEG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [SEG_W-1:0] rd_data
);

   logic [SEG_W-1:0] seg_q [NUM_SEG];

   if (NUM_SEG < 2 || (1 << IDX_W) != NUM_SEG) begin : g_bad_depth
      $error("hpt_seg_file: NUM_SEG must be a power of two of at least 2");
   end

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[g] <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            seg_q[g] <= wr_data;
      end
   end

   assign rd_data = seg_q[rd_idx];

   // R1: a write is present in its entry one cycle later
   a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> seg_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/hpt_seg_decode.sv
module hpt_seg_decode #(
   parameter int SEG_W    = 32,
   parameter int DS_BIT   = 31,
   parameter int KSUP_BIT = 30,
   parameter int KUSR_BIT = 29,
   parameter int NX_BIT   = 28,
   parameter int VSID_W   = 24
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic              user,
   output logic              key,
   output logic              ds,
   output logic              nx,
   output logic [VSID_W-1:0] vsid
);

   if (VSID_W > NX_BIT || DS_BIT >= SEG_W) begin : g_bad_layout
      $error("hpt_seg_decode: descriptor fields overlap or exceed width");
   end

   assign key  = user ? seg[KUSR_BIT] : seg[KSUP_BIT];
   assign ds   = seg[DS_BIT];
   assign nx   = seg[NX_BIT];
   assign vsid = seg[VSID_W-1:0];

endmodule

// File: rtl/hpt_hash_gen.sv
module hpt_hash_gen #(
   parameter int ADDR_W    = 32,
   parameter int SEL_W     = 4,
   parameter int PAGE_BITS = 12,
   parameter int VSID_W    = 24,
   parameter int HASH_SH   = 6,
   parameter int ORG_SH    = 16,
   parameter int HTAB_W    = 9,
   parameter int TAG_SH    = 7,
   parameter int API_DROP  = 10
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [VSID_W-1:0] vsid,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] pri_addr,
   output logic [ADDR_W-1:0] sec_addr,
   output logic [ADDR_W-1:0] tag
);

   localparam int OFF_W    = ADDR_W - SEL_W;
   localparam int PIDX_W   = OFF_W - PAGE_BITS;
   localparam int HASH_W   = ORG_SH + HTAB_W - HASH_SH;
   localparam int LOW_ONES = ORG_SH - HASH_SH;

   if (VSID_W < HASH_W || VSID_W < PIDX_W) begin : g_bad_vsid
      $error("hpt_hash_gen: identifier narrower than hash or page index");
   end
   if (ORG_SH + HTAB_W > ADDR_W || LOW_ONES < 1) begin : g_bad_mask
      $error("hpt_hash_gen: table mask does not fit the address");
   end
   if (VSID_W + TAG_SH > ADDR_W || PIDX_W - API_DROP > TAG_SH) begin : g_bad_tag
      $error("hpt_hash_gen: tag fields do not fit");
   end

   logic [PIDX_W-1:0] pidx;
   logic [VSID_W-1:0] mix;
   logic [HASH_W-1:0] h_pri, h_sec, h_mask;
   logic [ADDR_W-1:0] origin;

   assign pidx   = ea[OFF_W-1:PAGE_BITS];
   assign mix    = vsid ^ VSID_W'(pidx);
   assign h_pri  = mix[HASH_W-1:0];
   assign h_sec  = ~h_pri;
   assign h_mask = {base[HTAB_W-1:0], {LOW_ONES{1'b1}}};
   assign origin = {base[ADDR_W-1:ORG_SH], {ORG_SH{1'b0}}};

   assign pri_addr = origin | (ADDR_W'(h_pri & h_mask) << HASH_SH);
   assign sec_addr = origin | (ADDR_W'(h_sec & h_mask) << HASH_SH);
   assign tag      = (ADDR_W'(vsid) << TAG_SH) | ADDR_W'(pidx >> API_DROP);

endmodule

// File: rtl/hpt_outcome.sv
module hpt_outcome
   import hpt_pkg::*;
#(
   parameter bit NX_ENABLE = 1'b1
) (
   input  logic       ds,
   input  logic       nx,
   input  logic       key,
   input  logic [2:0] acc,
   input  logic       write,
   output logic [2:0] status,
   output logic       use_page,
   output logic       real_is_ea
);

   logic nx_fault;

   if (NX_ENABLE) begin : g_nx_on
      assign nx_fault = nx && (acc == ACC_CODE);
   end else begin : g_nx_off
      assign nx_fault = 1'b0;
   end

   always_comb begin
      status     = ST_DS_BAD;
      use_page   = 1'b0;
      real_is_ea = 1'b0;
      if (ds) begin
         unique case (acc)
            ACC_INT: begin
               if (write ? !key : key) begin
                  status = ST_DS_DENY;
               end else begin
                  status     = ST_DS_OK;
                  real_is_ea = 1'b1;
               end
            end
            ACC_CACHE: begin
               status     = ST_CACHE_NOP;
               real_is_ea = 1'b1;
            end
            default: status = ST_DS_BAD;
         endcase
      end else if (nx_fault) begin
         status = ST_NOEXEC;
      end else begin
         status   = ST_PAGE;
         use_page = 1'b1;
      end
   end

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
   import hpt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_SEG   = 16,
   parameter int PAGE_BITS = 12,
   parameter int VSID_W    = 24,
   parameter int HASH_SH   = 6,
   parameter int ORG_SH    = 16,
   parameter int HTAB_W    = 9,
   parameter int TAG_SH    = 7,
   parameter int API_DROP  = 10,
   parameter bit NX_ENABLE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sr_wr_en,
   input  logic [3:0]  sr_wr_idx,
   input  logic [31:0] sr_wr_data,
   input  logic [31:0] tbl_base,
   input  logic        in_valid,
   input  logic [31:0] in_ea,
   input  logic [2:0]  in_acc,
   input  logic        in_write,
   input  logic        in_user,
   output logic        out_valid,
   output logic [2:0]  out_status,
   output logic        out_key,
   output logic [31:0] out_pri_addr,
   output logic [31:0] out_sec_addr,
   output logic [31:0] out_tag,
   output logic [31:0] out_real
);

   localparam int SEL_W = $clog2(NUM_SEG);

   if (ADDR_W != 32 || SEL_W != 4) begin : g_bad_top
      $error("hpt_addr_gen: port widths fixed at 32-bit address and 16 segments");
   end

   logic [ADDR_W-1:0] seg_word;
   logic              key_c, ds_c, nx_c, use_page_c, real_ea_c;
   logic [VSID_W-1:0] vsid_c;
   logic [ADDR_W-1:0] pri_c, sec_c, tag_c;
   logic [2:0]        status_c;

   hpt_seg_file #(.NUM_SEG(NUM_SEG), .SEG_W(ADDR_W)) i_seg_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sr_wr_en),
      .wr_idx  (sr_wr_idx),
      .wr_data (sr_wr_data),
      .rd_idx  (in_ea[ADDR_W-1 -: SEL_W]),
      .rd_data (seg_word)
   );

   hpt_seg_decode #(.SEG_W(ADDR_W), .VSID_W(VSID_W)) i_seg_decode (
      .seg  (seg_word),
      .user (in_user),
      .key  (key_c),
      .ds   (ds_c),
      .nx   (nx_c),
      .vsid (vsid_c)
   );

   hpt_hash_gen #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .PAGE_BITS(PAGE_BITS), .VSID_W(VSID_W),
      .HASH_SH(HASH_SH), .ORG_SH(ORG_SH), .HTAB_W(HTAB_W),
      .TAG_SH(TAG_SH), .API_DROP(API_DROP)
   ) i_hash_gen (
      .ea       (in_ea),
      .vsid     (vsid_c),
      .base     (tbl_base),
      .pri_addr (pri_c),
      .sec_addr (sec_c),
      .tag      (tag_c)
   );

   hpt_outcome #(.NX_ENABLE(NX_ENABLE)) i_outcome (
      .ds         (ds_c),
      .nx         (nx_c),
      .key        (key_c),
      .acc        (in_acc),
      .write      (in_write),
      .status     (status_c),
      .use_page   (use_page_c),
      .real_is_ea (real_ea_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_status   <= ST_CACHE_NOP;
         out_key      <= 1'b0;
         out_pri_addr <= '0;
         out_sec_addr <= '0;
         out_tag      <= '0;
         out_real     <= '1;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_status   <= status_c;
            out_key      <= key_c;
            out_pri_addr <= use_page_c ? pri_c : '0;
            out_sec_addr <= use_page_c ? sec_c : '0;
            out_tag      <= use_page_c ? tag_c : '0;
            out_real     <= real_ea_c ? in_ea : '1;
         end
      end
   end

   // R10: one strobe per request, one cycle later
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_real) && $stable(out_status) && $stable(out_pri_addr));
   // R7: a rejected fetch carries no addresses
   a_r7_noexec_clean: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_status == ST_NOEXEC |-> out_pri_addr == '0 && out_real == '1);
   // R5: secondary hash bits in the always-unmasked range mirror the primary
   a_r5_sec_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_status == ST_PAGE |->
         &(out_pri_addr[ORG_SH-1:HASH_SH] ^ out_sec_addr[ORG_SH-1:HASH_SH]));
   // R11: translated access leaves the real address invalid
   a_r11_page_real: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_status == ST_PAGE |-> out_real == '1);
   // R9: granted direct-store access passes the effective address through
   a_r9_ds_real: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_status == ST_DS_OK |-> out_real == $past(in_ea));

endmodule

// File: tb/test_hpt_addr_gen.sv
`timescale 1ns/1ps
module test_hpt_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_wr_en = 1'b0;
   logic [3:0]  sr_wr_idx = '0;
   logic [31:0] sr_wr_data = '0;
   logic [31:0] tbl_base = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_ea = '0;
   logic [2:0]  in_acc = '0;
   logic        in_write = 1'b0;
   logic        in_user = 1'b0;
   logic        out_valid, out_key;
   logic [2:0]  out_status;
   logic [31:0] out_pri_addr, out_sec_addr, out_tag, out_real;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   hpt_addr_gen i_hpt_addr_gen (.*);

   // {descriptor, ea, acc, write, user, expected status}
   localparam int NV = 22;
   localparam logic [71:0] VEC [NV] = '{
      {32'h00AB_CDEF, 32'h3123_4567, 3'd0, 1'b0, 1'b0, 3'b001},
      {32'h1000_0042, 32'h7000_1000, 3'd1, 1'b0, 1'b0, 3'b101},
      {32'h1000_0042, 32'h7FFF_F000, 3'd0, 1'b1, 1'b1, 3'b001},
      {32'h0000_1111, 32'h2ABC_D000, 3'd1, 1'b0, 1'b1, 3'b001},
      {32'h6000_1234, 32'h1FED_C000, 3'd0, 1'b0, 1'b1, 3'b001},
      {32'h00FF_FFFF, 32'hF000_0000, 3'd2, 1'b1, 1'b0, 3'b001},
      {32'h8000_0000, 32'h9000_0010, 3'd0, 1'b0, 1'b1, 3'b010},
      {32'hA000_0000, 32'hA000_0020, 3'd0, 1'b0, 1'b1, 3'b110},
      {32'hA000_0000, 32'hA000_0024, 3'd0, 1'b1, 1'b1, 3'b010},
      {32'hC000_0000, 32'hB000_0030, 3'd0, 1'b1, 1'b0, 3'b010},
      {32'hC000_0000, 32'hB000_0034, 3'd0, 1'b0, 1'b0, 3'b110},
      {32'h8000_0000, 32'hC000_0040, 3'd0, 1'b1, 1'b0, 3'b110},
      {32'h8000_0000, 32'hC000_0044, 3'd1, 1'b0, 1'b0, 3'b100},
      {32'h8000_0000, 32'hC000_0048, 3'd2, 1'b0, 1'b0, 3'b100},
      {32'h8000_0000, 32'hC000_004C, 3'd3, 1'b1, 1'b0, 3'b100},
      {32'h8000_0000, 32'hC000_0050, 3'd5, 1'b0, 1'b1, 3'b100},
      {32'h8000_0000, 32'hC000_0054, 3'd6, 1'b0, 1'b0, 3'b100},
      {32'h8000_0000, 32'hC000_0058, 3'd7, 1'b1, 1'b1, 3'b100},
      {32'hA000_0000, 32'hD000_0060, 3'd4, 1'b0, 1'b1, 3'b000},
      {32'h8000_0000, 32'hD000_0064, 3'd4, 1'b1, 1'b0, 3'b000},
      {32'h9000_0000, 32'hE000_0070, 3'd1, 1'b0, 1'b0, 3'b100},
      {32'h9000_0000, 32'hE000_0074, 3'd0, 1'b0, 1'b0, 3'b010}
   };

   function automatic logic [31:0] grp(input logic [31:0] base, input logic [31:0] vsid,
                                       input logic [31:0] ea, input bit second);
      logic [31:0] pi, h, m;
      pi = (ea & 32'h0FFF_FFFF) >> 12;
      h  = ((vsid ^ pi) << 6) & 32'h01FF_FFC0;
      if (second) h = ~h & 32'h01FF_FFC0;
      m  = ((base & 32'h0000_01FF) << 16) | 32'h0000_FFC0;
      return (base & 32'hFFFF_0000) | (h & m);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] ea, input logic [2:0] acc,
                         input logic wr, input logic usr);
      @(negedge clk);
      in_valid = 1'b1; in_ea = ea; in_acc = acc; in_write = wr; in_user = usr;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wr_seg(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      sr_wr_en = 1'b1; sr_wr_idx = idx; sr_wr_data = val;
      @(negedge clk);
      sr_wr_en = 1'b0;
   endtask

   task automatic run_table(input logic [31:0] base);
      for (int i = 0; i < NV; i++) begin
         logic [31:0] sr, ea, vsid, er, ep, es, et;
         logic [2:0]  acc, st;
         logic        wr, usr, ek;
         {sr, ea, acc, wr, usr, st} = VEC[i];
         tbl_base = base;
         wr_seg(ea[31:28], sr);
         lookup(ea, acc, wr, usr);
         vsid = sr & 32'h00FF_FFFF;
         ek   = usr ? sr[29] : sr[30];
         er   = (st == 3'b010 || st == 3'b000) ? ea : 32'hFFFF_FFFF;
         ep   = (st == 3'b001) ? grp(base, vsid, ea, 1'b0) : 32'h0;
         es   = (st == 3'b001) ? grp(base, vsid, ea, 1'b1) : 32'h0;
         et   = (st == 3'b001) ? ((vsid << 7) | (((ea & 32'h0FFF_FFFF) >> 12) >> 10)) : 32'h0;
         chk("R10", "out_valid", 32'(out_valid), 32'd1);
         chk("R3_R7_R8_R9_R11", "status", 32'(out_status), 32'(st));
         chk("R2", "key", 32'(out_key), 32'(ek));
         chk("R8_R9_R11", "real", out_real, er);
         chk("R4", "primary", out_pri_addr, ep);
         chk("R5", "secondary", out_sec_addr, es);
         chk("R6", "tag", out_tag, et);
      end
   endtask

   initial begin
      #(20ns * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held_real;
      logic [2:0]  held_st;
      repeat (3) @(negedge clk);
      // R11: reset values
      chk("R11", "reset out_valid", 32'(out_valid), 32'd0);
      chk("R11", "reset status", 32'(out_status), 32'd0);
      chk("R11", "reset real", out_real, 32'hFFFF_FFFF);
      chk("R11", "reset primary", out_pri_addr, 32'h0);
      rst_n = 1'b1;

      // R1: same-cycle write is not seen; a later lookup sees it
      @(negedge clk);
      tbl_base   = 32'h0040_0000;
      sr_wr_en   = 1'b1; sr_wr_idx = 4'd5; sr_wr_data = 32'h8000_0000;
      in_valid   = 1'b1; in_ea = 32'h5000_3000; in_acc = 3'd0; in_write = 1'b0; in_user = 1'b0;
      @(negedge clk);
      sr_wr_en = 1'b0; in_valid = 1'b0;
      chk("R1", "old descriptor used", 32'(out_status), 32'b001);
      chk("R1", "old descriptor primary", out_pri_addr,
          grp(32'h0040_0000, 32'h0, 32'h5000_3000, 1'b0));
      lookup(32'h5000_3000, 3'd0, 1'b0, 1'b0);
      chk("R1", "new descriptor used", 32'(out_status), 32'b010);
      chk("R1", "real passthrough", out_real, 32'h5000_3000);

      // R10: outputs hold and strobe drops while idle
      held_real = out_real; held_st = out_status;
      @(negedge clk);
      chk("R10", "single strobe", 32'(out_valid), 32'd0);
      in_ea = 32'h0000_0000; in_acc = 3'd1;
      repeat (3) @(negedge clk);
      chk("R10", "real held", out_real, held_real);
      chk("R10", "status held", 32'(held_st), 32'(out_status));
      chk("R10", "still idle", 32'(out_valid), 32'd0);

      run_table(32'h0F37_00A5);
      run_table(32'hFFFF_01FF);
      run_table(32'h1234_0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule